// File: doc/BRIEF.md
# Clock Divider Bank Update Sequencer

This block moves a bank of six clock divider groups to the ratios of a chosen performance level. A single-cycle start request carries a 2-bit level index. The block looks up the ratio set for that level in an internal table. It then rewrites the groups strictly one after another, and before it touches the next group it waits until every busy bit of the group it just wrote has cleared. A one-cycle done pulse marks the point where the last group goes idle.

Each group holds a 32-bit ratio register made of 4-bit nibbles. A ratio field is the low three bits of a nibble. The write into a group is a read-modify-write: only the bits of the fields listed in the table are replaced, and every other bit keeps its value. Each group also has a status vector with one busy bit per field, at bit 0 of that field's nibble. In this model a write sets those busy bits, and they stay set for `settle_i` cycles, sampled at the write. A per-group watchdog stops the update if a group stays busy too long. The block then raises an error flag and goes back to idle. Actual clock generation and glitch-free switching are not modelled.

Top module: `divbank_update`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are 0, and every ratio output holds the reset value `RST_VAL` (default all ones).
- R2: An accepted start sets `busy_o` on the next cycle. The groups are written one at a time in the order core (cpu0), auxiliary core (cpu1), memory controller (dmc0), top, left bus, right bus. Group g changes at the clock edge 1+g*(2+S) edges after the start edge, where S is `settle_i`. The update ends 6*(2+S) edges after the start edge.
- R3: Each write changes only bits [4i+2:4i] of the fields i that the group owns. Bit 3 of each nibble and every nibble the group does not own keep their previous value.
- R4: The cpu0 group owns fields 0..6. Its values are {0,3,7,3,3,0,1} at levels 0 and 1, {0,1,3,1,3,0,1} at level 2 and {0,0,1,0,3,1,1} at level 3, listed from field 0 upward.
- R5: The cpu1 group owns two fields. Bits [6:4] hold 3 and bits [2:0] hold 0, at every level.
- R6: The dmc0 group owns fields 0..7. Its values are {3,1,1,1,1,1,3,1} at levels 0 and 1, {7,1,1,2,1,1,3,1} at level 2 and {7,1,1,3,1,1,3,1} at level 3.
- R7: The top group owns fields 0..4. Its values are {3,7,4,5,1} at levels 0 and 1, {4,7,5,7,1} at level 2 and {5,7,7,7,1} at level 3.
- R8: The left and right bus groups own fields 0..1 and receive identical values: {3,1} at levels 0 and 1, {4,1} at level 2 and {5,1} at level 3.
- R9: After a write, a group's busy bits (bit 0 of each owned nibble) stay set for S cycles. The sequencer does not advance while any of them is set. With S=0 each group takes two cycles.
- R10: A start that arrives while `busy_o` is 1 is ignored. It changes neither the timing nor the ratio values of the update in progress.
- R11: `done_o` is a single-cycle pulse. It is raised in the cycle in which `busy_o` first reads 0 after a successful update.
- R12: If a group is still busy after `TIMEOUT` wait cycles (S >= `TIMEOUT`), the block goes idle TIMEOUT+1 edges after the start edge. It sets `err_o` and does not pulse `done_o`. The groups after the failing one stay unchanged, and `err_o` holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Update request, sampled while idle |
| level_i | input | 2 | Performance level index, taken with the start |
| settle_i | input | SETTLE_W | Busy duration of a group after its write, in cycles |
| busy_o | output | 1 | An update is in progress |
| done_o | output | 1 | One-cycle pulse when an update completes |
| err_o | output | 1 | A group timed out; held until the next accepted start |
| cpu0_div_o | output | 32 | cpu0 group ratio register |
| cpu1_div_o | output | 32 | cpu1 group ratio register |
| dmc0_div_o | output | 32 | dmc0 group ratio register |
| top_div_o | output | 32 | top group ratio register |
| lbus_div_o | output | 32 | left bus group ratio register |
| rbus_div_o | output | 32 | right bus group ratio register |

## Verification
The assertions assume that `start_i` and `level_i` are known and steady around each clock edge. They also assume that `settle_i` does not change between a start and the matching done or error. The bench drives every input on the falling edge, and it changes `settle_i` only while `busy_o` is low. The stimulus stays inside those limits. It also drives start pulses in the middle of an update, with a different level, so that the ignore rule is tested against values that would be visible if the rule failed.

// File: rtl/divbank_pkg.sv
package divbank_pkg;
  localparam int NGRP = 6;
  localparam int GW   = $clog2(NGRP);

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_WAIT} seq_st_t;

  function automatic int nfields(input int g);
    case (g)
      0: return 7;
      1: return 2;
      2: return 8;
      3: return 5;
      default: return 2;
    endcase
  endfunction

  // low three bits of every owned nibble
  function automatic logic [31:0] own_mask(input int g);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 8; i++)
      if (i < nfields(g)) m[4*i +: 3] = 3'b111;
    return m;
  endfunction

  // busy flag sits at bit 0 of each owned nibble
  function automatic logic [31:0] stat_mask(input int g);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 8; i++)
      if (i < nfields(g)) m[4*i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] ratios(input int g, input logic [1:0] lvl);
    case (g)
      0: case (lvl)
           2'd2:    return 32'h0103_1310;
           2'd3:    return 32'h0113_0100;
           default: return 32'h0103_3730;
         endcase
      1: return 32'h0000_0030;
      2: case (lvl)
           2'd2:    return 32'h1311_2117;
           2'd3:    return 32'h1311_3117;
           default: return 32'h1311_1113;
         endcase
      3: case (lvl)
           2'd2:    return 32'h0001_7574;
           2'd3:    return 32'h0001_7775;
           default: return 32'h0001_5473;
         endcase
      default: case (lvl)
           2'd2:    return 32'h0000_0014;
           2'd3:    return 32'h0000_0015;
           default: return 32'h0000_0013;
         endcase
    endcase
  endfunction
endpackage

// File: rtl/divbank_group.sv
module divbank_group
  import divbank_pkg::*;
#(
  parameter int          GRP      = 0,
  parameter int          SETTLE_W = 8,
  parameter logic [31:0] RST_VAL  = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [31:0]         wdata_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [31:0]         ratio_o,
  output logic [31:0]         stat_o
);
  localparam logic [31:0] SMASK = stat_mask(GRP);

  logic [SETTLE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_o <= RST_VAL;
      hold_q  <= '0;
    end else if (wr_i) begin
      ratio_o <= wdata_i;
      hold_q  <= settle_i;
    end else if (hold_q != '0) begin
      hold_q  <= hold_q - 1'b1;
    end
  end

  assign stat_o = (hold_q != '0) ? SMASK : '0;
endmodule

// File: rtl/divbank_fsm.sv
module divbank_fsm
  import divbank_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    level_i,
  input  logic [31:0]   stat_i,
  output logic [GW-1:0] grp_o,
  output logic [1:0]    lvl_o,
  output logic          wr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int TCW = $clog2(TIMEOUT + 1);
  localparam logic [TCW-1:0] TLAST = TCW'(TIMEOUT - 1);
  localparam logic [GW-1:0]  GLAST = GW'(NGRP - 1);

  seq_st_t        st_q;
  logic [TCW-1:0] tcnt_q;
  logic           grp_busy;

  assign grp_busy = (stat_i & stat_mask(int'(grp_o))) != '0;
  assign wr_o     = (st_q == ST_WR);
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      grp_o  <= '0;
      lvl_o  <= '0;
      tcnt_q <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_WR;
          grp_o <= '0;
          lvl_o <= level_i;
          err_o <= 1'b0;
        end
        ST_WR: begin
          st_q   <= ST_WAIT;
          tcnt_q <= '0;
        end
        ST_WAIT: begin
          if (grp_busy) begin
            if (tcnt_q == TLAST) begin
              err_o <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end else if (grp_o == GLAST) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            grp_o <= grp_o + 1'b1;
            st_q  <= ST_WR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divbank_update.sv
module divbank_update
  import divbank_pkg::*;
#(
  parameter int          TIMEOUT  = 16,
  parameter int          SETTLE_W = 8,
  parameter logic [31:0] RST_VAL  = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          level_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [31:0]         cpu0_div_o,
  output logic [31:0]         cpu1_div_o,
  output logic [31:0]         dmc0_div_o,
  output logic [31:0]         top_div_o,
  output logic [31:0]         lbus_div_o,
  output logic [31:0]         rbus_div_o
);
  logic [GW-1:0] grp;
  logic [1:0]    lvl;
  logic          wr;
  logic [31:0]   wdata;
  logic [31:0]   cur_ratio, cur_stat;
  logic [31:0]   ratio_a [NGRP];
  logic [31:0]   stat_a  [NGRP];

  divbank_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
    .stat_i(cur_stat), .grp_o(grp), .lvl_o(lvl), .wr_o(wr),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    divbank_group #(.GRP(g), .SETTLE_W(SETTLE_W), .RST_VAL(RST_VAL)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr && (grp == GW'(g))),
      .wdata_i(wdata), .settle_i(settle_i),
      .ratio_o(ratio_a[g]), .stat_o(stat_a[g])
    );
  end

  always_comb begin
    cur_ratio = '0;
    cur_stat  = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp == GW'(g)) begin
        cur_ratio = ratio_a[g];
        cur_stat  = stat_a[g];
      end
    end
  end

  // read-modify-write: clear owned fields, insert table values
  assign wdata = (cur_ratio & ~own_mask(int'(grp))) | ratios(int'(grp), lvl);

  assign cpu0_div_o = ratio_a[0];
  assign cpu1_div_o = ratio_a[1];
  assign dmc0_div_o = ratio_a[2];
  assign top_div_o  = ratio_a[3];
  assign lbus_div_o = ratio_a[4];
  assign rbus_div_o = ratio_a[5];
endmodule

// File: rtl/divbank_update_chk.sv
module divbank_update_chk #(
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [1:0]          level_i,
  input logic [SETTLE_W-1:0] settle_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                err_o,
  input logic [31:0]         cpu0_div_o,
  input logic [31:0]         cpu1_div_o,
  input logic [31:0]         dmc0_div_o,
  input logic [31:0]         top_div_o,
  input logic [31:0]         lbus_div_o,
  input logic [31:0]         rbus_div_o
);
  p_start_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !err_o));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(cpu0_div_o) && $stable(cpu1_div_o) &&
      $stable(dmc0_div_o) && $stable(top_div_o) && $stable(lbus_div_o) &&
      $stable(rbus_div_o)));

  p_bus_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> (lbus_div_o == rbus_div_o));

  p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!busy_o && $fell(busy_o)));
endmodule

bind divbank_update divbank_update_chk #(.SETTLE_W(SETTLE_W)) u_chk (.*);

// File: tb/sim_divbank_update.sv
module sim_divbank_update;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  level_i = 2'd0;
  logic [7:0]  settle_i = 8'd0;
  logic        busy_o, done_o, err_o;
  logic [31:0] cpu0_div_o, cpu1_div_o, dmc0_div_o, top_div_o, lbus_div_o, rbus_div_o;

  always #10 clk = ~clk;

  divbank_update #(.TIMEOUT(TMO), .SETTLE_W(8), .RST_VAL(32'hFFFF_FFFF)) u0 (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit          m_act = 0, m_fail = 0, m_done = 0, m_err = 0;
  int          m_t = 0, m_len = 0, m_s = 0;
  int          m_lvl = 0;
  logic [31:0] m_reg [6];

  function automatic int nf(int g);
    int n[6] = '{7, 2, 8, 5, 2, 2};
    return n[g];
  endfunction

  function automatic int fval(int g, int lvl, int i);
    int c0a[7] = '{0,3,7,3,3,0,1};
    int c0b[7] = '{0,1,3,1,3,0,1};
    int c0c[7] = '{0,0,1,0,3,1,1};
    int c1[2]  = '{0,3};
    int dma[8] = '{3,1,1,1,1,1,3,1};
    int dmb[8] = '{7,1,1,2,1,1,3,1};
    int dmc[8] = '{7,1,1,3,1,1,3,1};
    int tpa[5] = '{3,7,4,5,1};
    int tpb[5] = '{4,7,5,7,1};
    int tpc[5] = '{5,7,7,7,1};
    int bsa[2] = '{3,1};
    int bsb[2] = '{4,1};
    int bsc[2] = '{5,1};
    case (g)
      0: return (lvl == 2) ? c0b[i] : (lvl == 3) ? c0c[i] : c0a[i];
      1: return c1[i];
      2: return (lvl == 2) ? dmb[i] : (lvl == 3) ? dmc[i] : dma[i];
      3: return (lvl == 2) ? tpb[i] : (lvl == 3) ? tpc[i] : tpa[i];
      default: return (lvl == 2) ? bsb[i] : (lvl == 3) ? bsc[i] : bsa[i];
    endcase
  endfunction

  function automatic logic [31:0] apply(int g, int lvl, logic [31:0] old);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < nf(g); i++) r[4*i +: 3] = 3'(fval(g, lvl, i));
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_err = 0; m_t = 0;
      for (int g = 0; g < 6; g++) m_reg[g] = 32'hFFFF_FFFF;
    end else begin
      m_done = 0;
      if (m_act) begin
        m_t++;
        for (int g = 0; g < 6; g++)
          if (m_t == 1 + g*(2+m_s) && (!m_fail || g == 0))
            m_reg[g] = apply(g, m_lvl, m_reg[g]);
        if (m_t == m_len) begin
          m_act = 0;
          if (m_fail) m_err = 1; else m_done = 1;
        end
      end else if (start_i) begin
        m_act = 1; m_t = 0; m_err = 0;
        m_s = int'(settle_i); m_lvl = int'(level_i);
        m_fail = (m_s >= TMO);
        m_len = m_fail ? TMO + 1 : 6*(2+m_s);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] dut_reg(int g);
    case (g)
      0: return cpu0_div_o;
      1: return cpu1_div_o;
      2: return dmc0_div_o;
      3: return top_div_o;
      4: return lbus_div_o;
      default: return rbus_div_o;
    endcase
  endfunction

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R10 busy", 32'(busy_o), 32'(m_act));
      chk("R11 done", 32'(done_o), 32'(m_done));
      chk("R12 err", 32'(err_o), 32'(m_err));
      chk("R2 R3 R4 cpu0", cpu0_div_o, m_reg[0]);
      chk("R2 R3 R5 cpu1", cpu1_div_o, m_reg[1]);
      chk("R2 R3 R6 dmc0", dmc0_div_o, m_reg[2]);
      chk("R2 R3 R7 top", top_div_o, m_reg[3]);
      chk("R2 R8 lbus", lbus_div_o, m_reg[4]);
      chk("R2 R8 rbus", rbus_div_o, m_reg[5]);
    end
  end

  task automatic run(int lvl, int s, bit poke);
    @(negedge clk);
    settle_i = 8'(s); level_i = 2'(lvl); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin   // R10: restarts while busy with another level
      repeat (3) @(negedge clk);
      level_i = 2'(3 - lvl); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2 + s) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 err", 32'(err_o), 32'd0);
    for (int g = 0; g < 6; g++) chk("R1 reg", dut_reg(g), 32'hFFFF_FFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 3, 0);        // R4 R6 R7 level 0 values
    run(2, 0, 0);        // R9 zero settle
    run(3, 5, 1);        // R10 ignored restarts
    run(1, TMO-1, 0);    // R12 just inside the limit
    run(2, TMO, 0);      // R12 timeout on cpu0
    run(3, 2, 0);        // R12 err cleared; R3 from partial state
    // R3 direct: bit 3 of each nibble preserved
    chk("R3 kept bits", cpu0_div_o & 32'h8888_8888, 32'h8888_8888);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule